// File: doc/BRIEF.md
# VDP Host Port with Register Unlock

This block is the processor-facing side of a video display processor. The CPU sees two byte-wide ports, a data port and a control port, selected by one line. Bytes written to the control port arrive in pairs: the first byte is held, and the top two bits of the second byte decide what the pair means. The pair is either a write to one of the display registers, or a new address for the video memory pointer. A read address also starts a read-ahead from memory. Data-port accesses move bytes to or from video memory through a simple synchronous memory bus and step a 14-bit pointer that wraps at 16 K. A status read on the control port returns the status register chosen by a selector register.

After reset only the eight base registers can be written. Register numbers above 7 fold onto 0 to 7. Writing the key value 0x1C to register 57 on two register writes in a row opens the full register file of 64 entries. This lets older software that writes stray high register numbers keep working, while newer software can reach the extended set. The whole register file is presented as a flat vector to the rest of the display pipeline.

Top module: `vdp_cpu_port`

## Requirements
- R1: After reset all 64 registers read 0, the port is locked, the vertical-sync flag is clear, `cpu_rdata` is 0 and no memory access is issued.
- R2: On the control port the first byte of a pair is held. If the second byte has bits [7:6] = 2'b10, the held byte is written to the register numbered by bits [5:0] of the second byte.
- R3: While locked, a register write lands on register (number mod 8): register 15 lands on 7, register 57 lands on 1, and registers 8 to 63 keep their value.
- R4: Two register writes in a row of value 0x1C to register 57 unlock the port, and every later register write reaches its own number. Any other register write between the two clears the progress. Data-port accesses do not clear it. While still locked, the key writes themselves land on register 1.
- R5: A second byte with bits [7:6] = 2'b01 or 2'b11 sets the pointer to {second[5:0], first} and issues no memory access.
- R6: A second byte with bits [7:6] = 2'b00 sets a read address. The block issues one memory read at {second[5:0], first} and leaves the pointer one above it, so the first data-port read returns the byte at that address.
- R7: A data-port write issues one memory write of the byte at the pointer, then adds 1 to the pointer modulo 16384.
- R8: A data-port read returns the read-ahead byte, issues a memory read at the pointer, then adds 1 modulo 16384.
- R9: Bits [3:0] of register 15 select the status value. 0 gives {vsync flag, 7'b0}. 1 gives {3'b111 device ID, 5'b0}. 14 gives the version byte 0x13. Any other value gives 0.
- R10: A `vsync_pulse` sets the flag. A status read with select 0 clears it, and reads with other selects leave it alone. If a pulse and a clearing read fall in the same cycle, the flag ends up set.
- R11: Any data-port access or status read makes the next control byte a first byte.
- R12: `cpu_rdata` and the memory outputs are registered and change on the clock edge that samples the strobe. `mem_rdata` is valid one cycle after `mem_re`. CPU strobes are one cycle long and at least 4 cycles apart, and memory write and read never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_ctl | input | 1 | Port select: 1 = control/status, 0 = data |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Registered CPU read byte |
| vsync_pulse | input | 1 | Sets the vertical-sync status flag |
| mem_addr | output | 14 | Video memory address |
| mem_we | output | 1 | Video memory write enable |
| mem_re | output | 1 | Video memory read enable |
| mem_wdata | output | 8 | Video memory write byte |
| mem_rdata | input | 8 | Video memory read byte, one cycle after mem_re |
| regs_flat | output | 512 | Register file, register n at bits [8n+7:8n] |

## Verification
The bench sweeps every register number from 8 to 63 twice, once locked and once unlocked. A design that masked the wrong bits, or let a locked write reach a high register, shows a wrong value in either the folded or the direct slot. The unlock run is first broken by a register write between the two keys, which must leave the port locked, and then by a data write between them, which must not. A design that counted non-consecutive keys, or that cleared progress on memory traffic, ends up in the wrong lock state. Read addresses are spread across the 16 K space and include 0x3FFF, so a missing prefetch, an off-by-one pointer or a missing wrap returns the pattern byte of the wrong address. The status tests cover clear-on-read for select 0 only, a pulse arriving together with a clearing read, and a control byte orphaned by a data or status access. A design that skipped the toggle reset would decode the next byte as a second byte and write the wrong register.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;

  // Meaning of bits [7:6] of the second control byte
  typedef enum logic [1:0] {
    CMD_RD_ADDR  = 2'b00,
    CMD_WR_ADDR  = 2'b01,
    CMD_REG_WR   = 2'b10,
    CMD_WR_ADDR2 = 2'b11
  } ctl_cmd_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/vdp_ctl_seq.sv
module vdp_ctl_seq
  import vdp_port_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int NUM_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              flush,
  input  logic [BYTE_W-1:0] wdata,
  output logic              reg_ev,
  output logic [NUM_W-1:0]  reg_num,
  output logic [BYTE_W-1:0] reg_val,
  output logic              adr_ev,
  output logic              adr_rd,
  output logic [ADDR_W-1:0] adr_val
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic              have_lo_q;
  logic [BYTE_W-1:0] lo_q;
  ctl_cmd_e          cmd;
  logic              second;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_lo_q <= 1'b0;
      lo_q      <= '0;
    end else if (ctl_wr) begin
      if (have_lo_q) begin
        have_lo_q <= 1'b0;
      end else begin
        have_lo_q <= 1'b1;
        lo_q      <= wdata;
      end
    end else if (flush) begin
      have_lo_q <= 1'b0;
    end
  end

  always_comb begin
    cmd     = ctl_cmd_e'(wdata[BYTE_W-1 -: 2]);
    second  = ctl_wr && have_lo_q;
    reg_ev  = second && (cmd == CMD_REG_WR);
    adr_ev  = second && (cmd != CMD_REG_WR);
    adr_rd  = (cmd == CMD_RD_ADDR);
    reg_num = wdata[NUM_W-1:0];
    reg_val = lo_q;
    adr_val = {wdata[HI_W-1:0], lo_q};
  end

endmodule

// File: rtl/vdp_reg_bank.sv
module vdp_reg_bank
  import vdp_port_pkg::*;
#(
  parameter int              NREG      = 64,
  parameter int              NUM_W     = 6,
  parameter int              BASE_REGS = 8,
  parameter int              KEY_REG   = 57,
  parameter logic [BYTE_W-1:0] KEY_VAL = 8'h1C,
  parameter int              SEL_REG   = 15,
  parameter int              SEL_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_ev,
  input  logic [NUM_W-1:0]       wr_num,
  input  logic [BYTE_W-1:0]      wr_val,
  output logic [NREG*BYTE_W-1:0] regs_flat,
  output logic [SEL_W-1:0]       status_sel,
  output logic                   unlocked,
  output logic                   key_hit
);
  localparam int BASE_W = $clog2(BASE_REGS);

  logic [BYTE_W-1:0] bank_q [NREG];
  logic              armed_q;
  logic              open_q;
  logic [NUM_W-1:0]  eff_num;

  always_comb begin
    key_hit = wr_ev && (wr_num == NUM_W'(KEY_REG)) && (wr_val == KEY_VAL);
    eff_num = open_q ? wr_num
                     : {{(NUM_W-BASE_W){1'b0}}, wr_num[BASE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (wr_ev) begin
      bank_q[eff_num] <= wr_val;
    end
  end

  // Unlock needs two key writes with no other register write between
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      open_q  <= 1'b0;
    end else if (wr_ev) begin
      if (key_hit) begin
        if (armed_q) open_q <= 1'b1;
        armed_q <= !armed_q;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*BYTE_W +: BYTE_W] = bank_q[g];
  end

  assign status_sel = bank_q[SEL_REG][SEL_W-1:0];
  assign unlocked   = open_q;

endmodule

// File: rtl/vdp_addr_unit.sv
module vdp_addr_unit
  import vdp_port_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adr_ev,
  input  logic              adr_rd,
  input  logic [ADDR_W-1:0] adr_val,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [BYTE_W-1:0] rbuf
);
  logic [ADDR_W-1:0] ptr_q;
  logic              fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
      fill_q    <= 1'b0;
      rbuf      <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      fill_q <= mem_re;
      if (fill_q) rbuf <= mem_rdata;
      if (adr_ev) begin
        if (adr_rd) begin
          mem_addr <= adr_val;
          mem_re   <= 1'b1;
          ptr_q    <= adr_val + 1'b1;
        end else begin
          ptr_q <= adr_val;
        end
      end else if (dat_wr) begin
        mem_addr  <= ptr_q;
        mem_we    <= 1'b1;
        mem_wdata <= wdata;
        ptr_q     <= ptr_q + 1'b1;
      end else if (dat_rd) begin
        mem_addr <= ptr_q;
        mem_re   <= 1'b1;
        ptr_q    <= ptr_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vdp_stat_unit.sv
module vdp_stat_unit
  import vdp_port_pkg::*;
#(
  parameter int          SEL_W   = 4,
  parameter logic [2:0]  DEV_ID  = 3'b111,
  parameter logic [7:0]  VERSION = 8'h13,
  parameter int          ID_IDX  = 1,
  parameter int          VER_IDX = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync_pulse,
  input  logic              st_rd,
  input  logic [SEL_W-1:0]  sel,
  output logic [BYTE_W-1:0] st_val,
  output logic              vs_flag
);
  logic flag_q;

  always_comb begin
    if (sel == '0)                    st_val = {flag_q, 7'b0};
    else if (sel == SEL_W'(ID_IDX))   st_val = {DEV_ID, 5'b0};
    else if (sel == SEL_W'(VER_IDX))  st_val = VERSION;
    else                              st_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                          flag_q <= 1'b0;
    else if (vsync_pulse)             flag_q <= 1'b1;
    else if (st_rd && (sel == '0))    flag_q <= 1'b0;
  end

  assign vs_flag = flag_q;

endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
  import vdp_port_pkg::*;
#(
  parameter int          NREG    = 64,
  parameter int          ADDR_W  = 14,
  parameter int          KEY_REG = 57,
  parameter logic [7:0]  KEY_VAL = 8'h1C,
  parameter int          SEL_REG = 15,
  parameter logic [2:0]  DEV_ID  = 3'b111,
  parameter logic [7:0]  VERSION = 8'h13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_wr,
  input  logic                   cpu_rd,
  input  logic                   cpu_ctl,
  input  logic [7:0]             cpu_wdata,
  output logic [7:0]             cpu_rdata,
  input  logic                   vsync_pulse,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_we,
  output logic                   mem_re,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic [NREG*8-1:0]      regs_flat
);
  localparam int NUM_W = $clog2(NREG);
  localparam int SEL_W = 4;

  logic              dat_wr, dat_rd, ctl_wr, st_rd, flush;
  logic              ev_reg;
  logic [NUM_W-1:0]  ev_num;
  logic [7:0]        ev_val;
  logic              adr_ev, adr_rd;
  logic [ADDR_W-1:0] adr_val;
  logic [SEL_W-1:0]  st_sel;
  logic [7:0]        st_val, rbuf;
  logic              unlocked, key_hit, vs_flag;

  always_comb begin
    dat_wr = cpu_wr && !cpu_ctl;
    ctl_wr = cpu_wr &&  cpu_ctl;
    dat_rd = cpu_rd && !cpu_ctl;
    st_rd  = cpu_rd &&  cpu_ctl;
    flush  = dat_wr || dat_rd || st_rd;
  end

  vdp_ctl_seq #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .flush(flush), .wdata(cpu_wdata),
    .reg_ev(ev_reg), .reg_num(ev_num), .reg_val(ev_val),
    .adr_ev(adr_ev), .adr_rd(adr_rd), .adr_val(adr_val)
  );

  vdp_reg_bank #(.NREG(NREG), .NUM_W(NUM_W), .BASE_REGS(8), .KEY_REG(KEY_REG),
                 .KEY_VAL(KEY_VAL), .SEL_REG(SEL_REG), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .wr_ev(ev_reg), .wr_num(ev_num), .wr_val(ev_val),
    .regs_flat(regs_flat), .status_sel(st_sel), .unlocked(unlocked), .key_hit(key_hit)
  );

  vdp_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .adr_ev(adr_ev), .adr_rd(adr_rd), .adr_val(adr_val),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wdata(cpu_wdata), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .rbuf(rbuf)
  );

  vdp_stat_unit #(.SEL_W(SEL_W), .DEV_ID(DEV_ID), .VERSION(VERSION)) u_stat (
    .clk(clk), .rst(rst), .vsync_pulse(vsync_pulse), .st_rd(st_rd), .sel(st_sel),
    .st_val(st_val), .vs_flag(vs_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (dat_rd) cpu_rdata <= rbuf;
    else if (st_rd)  cpu_rdata <= st_val;
  end

endmodule

// File: rtl/vdp_cpu_port_chk.sv
module vdp_cpu_port_chk #(
  parameter int NREG   = 64,
  parameter int ADDR_W = 14,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              cpu_ctl,
  input logic [7:0]        cpu_wdata,
  input logic              vsync_pulse,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [7:0]        mem_wdata,
  input logic [NREG*8-1:0] regs_flat,
  input logic              adr_ev,
  input logic              adr_rd,
  input logic [ADDR_W-1:0] adr_val,
  input logic              unlocked,
  input logic              key_hit,
  input logic              vs_flag,
  input logic [SEL_W-1:0]  st_sel
);
  localparam int BASE_BITS = 64;

  assert_store_issued_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_ctl) |=> (mem_we && mem_wdata == $past(cpu_wdata)));

  assert_fetch_issued_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_ctl) |=> mem_re);

  assert_waddr_no_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (adr_ev && !adr_rd) |=> !mem_re);

  assert_raddr_prefetch_R6: assert property (@(posedge clk) disable iff (rst)
    (adr_ev && adr_rd) |=> (mem_re && mem_addr == $past(adr_val)));

  assert_high_regs_held_R3: assert property (@(posedge clk) disable iff (rst)
    !unlocked |-> (regs_flat[NREG*8-1:BASE_BITS] == '0));

  assert_unlock_after_key_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_hit));

  assert_sr0_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_ctl && st_sel == '0 && !vsync_pulse) |=> !vs_flag);

  assert_pulse_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
    vsync_pulse |=> vs_flag);

  assert_mem_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

endmodule

bind vdp_cpu_port vdp_cpu_port_chk #(.NREG(NREG), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_ctl(cpu_ctl),
  .cpu_wdata(cpu_wdata), .vsync_pulse(vsync_pulse), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .regs_flat(regs_flat),
  .adr_ev(adr_ev), .adr_rd(adr_rd), .adr_val(adr_val), .unlocked(unlocked),
  .key_hit(key_hit), .vs_flag(vs_flag), .st_sel(st_sel)
);

// File: tb/sim_vdp_cpu_port.sv
module sim_vdp_cpu_port;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_ctl = 1'b0;
  logic [7:0]   cpu_wdata = '0;
  logic [7:0]   cpu_rdata;
  logic         vsync_pulse = 1'b0;
  logic [13:0]  mem_addr;
  logic         mem_we, mem_re;
  logic [7:0]   mem_wdata;
  logic [7:0]   mem_rdata = '0;
  logic [511:0] regs_flat;

  int n_chk = 0, n_fail = 0;
  int we_cnt = 0, re_cnt = 0;
  int we_addr = 0, we_data = 0, re_addr = 0;

  always #10 clk = ~clk;

  vdp_cpu_port u0 (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_ctl(cpu_ctl),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vsync_pulse(vsync_pulse),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .regs_flat(regs_flat)
  );

  function automatic logic [7:0] pat(input logic [13:0] a);
    return (a[7:0] ^ {2'b00, a[13:8]}) + 8'h3C;
  endfunction

  // Synchronous memory model: data one cycle after mem_re
  always @(posedge clk) if (mem_re) mem_rdata <= pat(mem_addr);

  always @(negedge clk) begin
    if (mem_we) begin we_cnt++; we_addr = int'(mem_addr); we_data = int'(mem_wdata); end
    if (mem_re) begin re_cnt++; re_addr = int'(mem_addr); end
  end

  function automatic int rg(input int n);
    return int'(regs_flat[n*8 +: 8]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic ctl, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_ctl = ctl; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_byte(input logic ctl, output int d);
    @(negedge clk); cpu_rd = 1'b1; cpu_ctl = ctl;
    @(negedge clk); cpu_rd = 1'b0; d = int'(cpu_rdata);
    repeat (3) @(negedge clk);
  endtask

  task automatic ctl_pair(input logic [7:0] lo, input logic [7:0] hi);
    wr_byte(1'b1, lo);
    wr_byte(1'b1, hi);
  endtask

  task automatic vs_pulse();
    @(negedge clk); vsync_pulse = 1'b1;
    @(negedge clk); vsync_pulse = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    int d, r0;
    logic [13:0] a;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int n = 0; n < 64; n++) chk("R1 reg", rg(n), 0);
    chk("R1 rdata", int'(cpu_rdata), 0);
    chk("R1 no mem", we_cnt + re_cnt, 0);
    rd_byte(1'b1, d); chk("R1 status", d, 0);

    // R2 base register writes
    for (int n = 0; n < 8; n++) begin
      ctl_pair(8'(n * 17 + 3), 8'(8'h80 | n));
      chk("R2 reg", rg(n), (n * 17 + 3) & 255);
    end

    // R3 locked folding of 8..63
    for (int n = 8; n < 64; n++) begin
      ctl_pair(8'(n ^ 8'h5A), 8'(8'h80 | n));
      chk("R3 folded", rg(n & 7), (n ^ 8'h5A) & 255);
      chk("R3 high held", rg(n), 0);
    end
    // R3 status select untouched while locked (reg 15 went to 7)
    vs_pulse();
    rd_byte(1'b1, d); chk("R3 R9 locked sel0", d, 8'h80);
    rd_byte(1'b1, d); chk("R10 cleared", d, 8'h00);

    // R4 unlock sequence
    ctl_pair(8'h1C, 8'hB9); chk("R3 key on reg1", rg(1), 8'h1C);
    ctl_pair(8'h00, 8'h82);                 // other reg write clears progress
    ctl_pair(8'h1C, 8'hB9);
    ctl_pair(8'h77, 8'h94);
    chk("R4 still locked fold", rg(4), 8'h77);
    chk("R4 still locked high", rg(20), 0);
    ctl_pair(8'h1C, 8'hB9);
    wr_byte(1'b0, 8'h55);                   // data write keeps progress
    ctl_pair(8'h1C, 8'hB9);
    chk("R4 reg57 untouched", rg(57), 0);
    ctl_pair(8'h66, 8'h94);
    chk("R4 unlocked direct", rg(20), 8'h66);
    chk("R4 fold gone", rg(4), 8'h77);
    for (int n = 8; n < 64; n++) begin
      ctl_pair(8'(n ^ 8'hA5), 8'(8'h80 | n));
      chk("R4 direct sweep", rg(n), (n ^ 8'hA5) & 255);
    end

    // R5 write address and wrap (R7)
    r0 = re_cnt;
    ctl_pair(8'hFE, 8'h7F);
    chk("R5 no fetch", re_cnt, r0);
    wr_byte(1'b0, 8'hAA); chk("R7 addr", we_addr, 14'h3FFE); chk("R7 data", we_data, 8'hAA);
    wr_byte(1'b0, 8'hBB); chk("R7 addr+1", we_addr, 14'h3FFF);
    wr_byte(1'b0, 8'hCC); chk("R7 wrap", we_addr, 0); chk("R7 data wrap", we_data, 8'hCC);
    ctl_pair(8'h34, 8'hC1);
    chk("R5 alt no fetch", re_cnt, r0);
    wr_byte(1'b0, 8'h12); chk("R5 alt addr", we_addr, 14'h0134);

    // R6 / R8 read address sweep
    for (int i = 0; i < 64; i++) begin
      a = 14'((i * 263 + 5) & 16'h3FFF);
      r0 = re_cnt;
      ctl_pair(a[7:0], {2'b00, a[13:8]});
      chk("R6 one fetch", re_cnt, r0 + 1);
      chk("R6 fetch addr", re_addr, int'(a));
      rd_byte(1'b0, d); chk("R6 first read", d, int'(pat(a)));
      rd_byte(1'b0, d); chk("R8 next read", d, int'(pat(a + 14'd1)));
    end
    ctl_pair(8'hFF, 8'h3F);
    rd_byte(1'b0, d); chk("R8 top", d, int'(pat(14'h3FFF)));
    rd_byte(1'b0, d); chk("R8 wrap", d, int'(pat(14'h0000)));

    // R9 / R10 status selection
    ctl_pair(8'h00, 8'h8F);
    rd_byte(1'b1, d); chk("R9 sel0 idle", d, 0);
    vs_pulse();
    ctl_pair(8'h01, 8'h8F);
    rd_byte(1'b1, d); chk("R9 id", d, 8'hE0);
    rd_byte(1'b1, d); chk("R10 id read keeps", d, 8'hE0);
    ctl_pair(8'h0E, 8'h8F);
    rd_byte(1'b1, d); chk("R9 version", d, 8'h13);
    ctl_pair(8'h05, 8'h8F);
    rd_byte(1'b1, d); chk("R9 other", d, 0);
    ctl_pair(8'h00, 8'h8F);
    rd_byte(1'b1, d); chk("R10 flag kept", d, 8'h80);
    rd_byte(1'b1, d); chk("R10 cleared", d, 0);
    @(negedge clk); cpu_rd = 1'b1; cpu_ctl = 1'b1; vsync_pulse = 1'b1;
    @(negedge clk); cpu_rd = 1'b0; vsync_pulse = 1'b0; d = int'(cpu_rdata);
    repeat (3) @(negedge clk);
    chk("R10 same cycle old", d, 0);
    rd_byte(1'b1, d); chk("R10 set wins", d, 8'h80);

    // R11 toggle reset
    ctl_pair(8'h00, 8'h83);
    wr_byte(1'b1, 8'h44);
    rd_byte(1'b1, d);
    ctl_pair(8'h99, 8'h83);
    chk("R11 status resets", rg(3), 8'h99);
    wr_byte(1'b1, 8'h11);
    rd_byte(1'b0, d);
    ctl_pair(8'h3C, 8'h84);
    chk("R11 data resets", rg(4), 8'h3C);
    chk("R12 no stray access", (mem_we && mem_re) ? 1 : 0, 0);

    finish_run();
  end
endmodule